// File: doc/BRIEF.md
# Integer Execute Unit

A purely combinational integer datapath for a 32-bit, three-register RISC pipeline. Each evaluation receives these inputs:

- a primary opcode
- a function code
- a constant shift distance
- two register operands
- a 16-bit immediate

From these it forms one result word. It also raises a valid flag for the write-back stage. Two fault flags cover a signed-overflow trap and an instruction the unit does not implement.

Register-format instructions carry opcode 0 and choose their operation through the function code. Immediate-format instructions choose through the opcode alone. The immediate is widened in one of two ways. Arithmetic and compare forms copy bit 15 into every upper bit. Logical forms fill the upper bits with zeros. Only the trapping add and subtract forms can signal overflow. The register-format instructions take no account of the immediate. The immediate-format instructions take no account of the function code and the shift distance.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0, function 0x20 (add), 0x21 (addu), 0x22 (sub) and 0x23 (subu) drive the result with rs+rt or rs-rt modulo 2^32. When no trap occurs, valid is raised.
- R2: With opcode 0, function 0x24 returns rs AND rt, 0x25 returns rs OR rt, and 0x27 returns NOT(rs OR rt), with valid raised.
- R3: With opcode 0, function 0x2A (signed) and 0x2B (unsigned) return 1 if rs is less than rt, else 0.
- R4: With opcode 0, function 0x00 shifts rt left and 0x02 shifts rt right, by shamt, with zero fill. The value of rs has no effect.
- R5: Opcodes 0x08 (addi), 0x09 (addiu) and 0x0A (slti, signed compare) use the immediate sign-extended from bit 15.
- R6: Opcodes 0x0C (andi) and 0x0D (ori) use the immediate zero-extended.
- R7: Opcode 0x0B (sltiu) compares rs against the sign-extended immediate as unsigned numbers.
- R8: Opcode 0x0F (lui) returns the immediate in bits 31:16 and zeros in bits 15:0.
- R9: Signed overflow on add, sub or addi raises ovf_trap, lowers valid and still presents the wrapped result. addu, subu and addiu never raise ovf_trap.
- R10: Any other opcode/function pair lowers valid, raises rsvd_instr, clears ovf_trap and drives the result to 0. Supported pairs never raise rsvd_instr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Primary opcode |
| funct | input | 6 | Function code for register-format operations |
| shamt | input | 5 | Constant shift distance |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| result | output | 32 | Computed result |
| result_valid | output | 1 | Result may be written back |
| ovf_trap | output | 1 | Signed overflow exception |
| rsvd_instr | output | 1 | Unsupported opcode/function pair |

## Verification
The hardest situation to reach is the exact edge of signed overflow. That edge includes a subtrahend equal to the most negative value, and an immediate sign bit that flips the sign of the addend. Uniform random operands almost never land there. The stimulus therefore picks operands from pools clustered around the largest positive and most negative values and small magnitudes. It adds directed pairs that sit just inside and just outside the representable range, for every trapping form and its non-trapping twin.

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int W = 32
) (
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  input  logic [4:0]   shamt,
  input  logic [W-1:0] rs_val,
  input  logic [W-1:0] rt_val,
  input  logic [15:0]  imm,
  output logic [W-1:0] result,
  output logic         result_valid,
  output logic         ovf_trap,
  output logic         rsvd_instr
);

  localparam int XW = W - 16;

  logic [W-1:0] imm_sx, imm_zx, sum, diff, sum_i;
  logic         ovf_add, ovf_sub, ovf_addi;

  assign imm_sx = {{XW{imm[15]}}, imm};
  assign imm_zx = {{XW{1'b0}}, imm};
  assign sum    = rs_val + rt_val;
  assign diff   = rs_val - rt_val;
  assign sum_i  = rs_val + imm_sx;

  assign ovf_add  = (rs_val[W-1] == rt_val[W-1]) && (sum[W-1]   != rs_val[W-1]);
  assign ovf_sub  = (rs_val[W-1] != rt_val[W-1]) && (diff[W-1]  != rs_val[W-1]);
  assign ovf_addi = (rs_val[W-1] == imm[15])     && (sum_i[W-1] != rs_val[W-1]);

  always_comb begin
    result       = '0;
    result_valid = 1'b1;
    ovf_trap     = 1'b0;
    rsvd_instr   = 1'b0;
    case (opcode)
      6'h00: begin
        case (funct)
          6'h20: begin result = sum;  ovf_trap = ovf_add; end
          6'h21: result = sum;
          6'h22: begin result = diff; ovf_trap = ovf_sub; end
          6'h23: result = diff;
          6'h24: result = rs_val & rt_val;
          6'h25: result = rs_val | rt_val;
          6'h27: result = ~(rs_val | rt_val);
          6'h2A: result = {{(W-1){1'b0}}, $signed(rs_val) < $signed(rt_val)};
          6'h2B: result = {{(W-1){1'b0}}, rs_val < rt_val};
          6'h00: result = rt_val << shamt;
          6'h02: result = rt_val >> shamt;
          default: rsvd_instr = 1'b1;
        endcase
      end
      6'h08: begin result = sum_i; ovf_trap = ovf_addi; end
      6'h09: result = sum_i;
      6'h0A: result = {{(W-1){1'b0}}, $signed(rs_val) < $signed(imm_sx)};
      6'h0B: result = {{(W-1){1'b0}}, rs_val < imm_sx};
      6'h0C: result = rs_val & imm_zx;
      6'h0D: result = rs_val | imm_zx;
      6'h0F: result = {imm, {XW{1'b0}}};
      default: rsvd_instr = 1'b1;
    endcase
    if (ovf_trap || rsvd_instr) result_valid = 1'b0;

    a_r10_exclusive: assert (!(result_valid && rsvd_instr));
    a_r10_quiet: assert (!rsvd_instr || (result == '0 && !ovf_trap));
    a_r9_trap_kills_valid: assert (!ovf_trap || !result_valid);
    a_r9_trap_forms_only: assert (!ovf_trap ||
        opcode == 6'h08 || (opcode == 6'h00 && (funct == 6'h20 || funct == 6'h22)));
    a_r3_boolean: assert (!((opcode == 6'h00 && (funct == 6'h2A || funct == 6'h2B)) ||
        opcode == 6'h0A || opcode == 6'h0B) || result[W-1:1] == '0);
    a_r8_low_clear: assert (opcode != 6'h0F || result[XW-1:0] == '0);
  end

endmodule

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [5:0]  opcode, funct;
  logic [4:0]  shamt;
  logic [31:0] rs_val, rt_val, result;
  logic [15:0] imm;
  logic        result_valid, ovf_trap, rsvd_instr;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  int_exec_unit #(.W(32)) dut_i (
    .opcode(opcode), .funct(funct), .shamt(shamt), .rs_val(rs_val), .rt_val(rt_val),
    .imm(imm), .result(result), .result_valid(result_valid), .ovf_trap(ovf_trap),
    .rsvd_instr(rsvd_instr));

  task automatic model(input [5:0] op, input [5:0] fn, input [4:0] sh, input [31:0] a,
                       input [31:0] b, input [15:0] im, output [31:0] r, output v,
                       output o, output x, output string tag);
    longint sa, sb, s;
    longint unsigned ua, ub;
    logic [31:0] se;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'(a); ub = longint'(b);
    se = {{16{im[15]}}, im};
    r = 0; v = 1; o = 0; x = 0; s = 0; tag = "R10";
    if (op == 0) begin
      case (fn)
        6'h20: begin s = sa + sb; r = s[31:0]; o = (s > 64'sd2147483647) || (s < -64'sd2147483648); tag = "R1"; end
        6'h21: begin r = a + b; tag = "R1"; end
        6'h22: begin s = sa - sb; r = s[31:0]; o = (s > 64'sd2147483647) || (s < -64'sd2147483648); tag = "R1"; end
        6'h23: begin r = a - b; tag = "R1"; end
        6'h24: begin r = a & b; tag = "R2"; end
        6'h25: begin r = a | b; tag = "R2"; end
        6'h27: begin r = ~(a | b); tag = "R2"; end
        6'h2A: begin r = (sa < sb) ? 1 : 0; tag = "R3"; end
        6'h2B: begin r = (ua < ub) ? 1 : 0; tag = "R3"; end
        6'h00: begin r = b; for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0}; tag = "R4"; end
        6'h02: begin r = b; for (int i = 0; i < sh; i++) r = {1'b0, r[31:1]}; tag = "R4"; end
        default: begin x = 1; v = 0; end
      endcase
    end else begin
      case (op)
        6'h08: begin s = sa + longint'($signed(se)); r = s[31:0]; o = (s > 64'sd2147483647) || (s < -64'sd2147483648); tag = "R5"; end
        6'h09: begin r = a + se; tag = "R5"; end
        6'h0A: begin r = (sa < longint'($signed(se))) ? 1 : 0; tag = "R5"; end
        6'h0B: begin r = (ua < longint'(se)) ? 1 : 0; tag = "R7"; end
        6'h0C: begin r = a & {16'h0, im}; tag = "R6"; end
        6'h0D: begin r = a | {16'h0, im}; tag = "R6"; end
        6'h0F: begin r = {im, 16'h0}; tag = "R8"; end
        default: begin x = 1; v = 0; end
      endcase
    end
    if (o) begin v = 0; tag = "R9"; end
  endtask

  task automatic apply(input [5:0] op, input [5:0] fn, input [4:0] sh, input [31:0] a,
                       input [31:0] b, input [15:0] im);
    logic [31:0] er; logic ev, eo, ex; string tag;
    @(negedge clk);
    opcode = op; funct = fn; shamt = sh; rs_val = a; rt_val = b; imm = im;
    #2;
    model(op, fn, sh, a, b, im, er, ev, eo, ex, tag);
    checks++;
    if (result !== er || result_valid !== ev || ovf_trap !== eo || rsvd_instr !== ex) begin
      failures++;
      $display("FAIL %s op=%h fn=%h a=%h b=%h imm=%h: got r=%h v=%b o=%b x=%b exp r=%h v=%b o=%b x=%b",
               tag, op, fn, a, b, im, result, result_valid, ovf_trap, rsvd_instr, er, ev, eo, ex);
    end
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 4)
      0: return $urandom;
      1: return 32'h7fffffff - ($urandom % 8);
      2: return 32'h80000000 + ($urandom % 8);
      default: return 32'($signed($urandom % 16) - 8);
    endcase
  endfunction

  localparam logic [11:0] OPS [18] = '{
    {6'h00,6'h20},{6'h00,6'h21},{6'h00,6'h22},{6'h00,6'h23},{6'h00,6'h24},{6'h00,6'h25},
    {6'h00,6'h27},{6'h00,6'h2A},{6'h00,6'h2B},{6'h00,6'h00},{6'h00,6'h02},{6'h08,6'h00},
    {6'h09,6'h00},{6'h0A,6'h00},{6'h0B,6'h00},{6'h0C,6'h00},{6'h0D,6'h00},{6'h0F,6'h00}};

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    opcode = 0; funct = 0; shamt = 0; rs_val = 0; rt_val = 0; imm = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    apply(6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0);                 // R4 all-zero word is a shift
    apply(6'h00, 6'h20, 0, 32'h7fffffff, 32'h1, 0);                 // R9 add overflow
    apply(6'h00, 6'h21, 0, 32'h7fffffff, 32'h1, 0);                 // R9 addu no trap
    apply(6'h00, 6'h20, 0, 32'h7ffffffe, 32'h1, 0);                 // R1 just inside
    apply(6'h00, 6'h22, 0, 32'h0, 32'h80000000, 0);                 // R9 sub of min
    apply(6'h00, 6'h22, 0, 32'hffffffff, 32'h80000000, 0);          // R1 no overflow
    apply(6'h00, 6'h23, 0, 32'h80000000, 32'h1, 0);                 // R9 subu no trap
    apply(6'h00, 6'h20, 0, 32'h80000000, 32'h80000000, 0);          // R9 negative overflow
    apply(6'h08, 6'h00, 0, 32'h7fff8000, 32'h0, 16'h8000);          // R5 sign-extended add
    apply(6'h08, 6'h00, 0, 32'h7fffffff, 32'h0, 16'h0001);          // R9 addi overflow
    apply(6'h09, 6'h00, 0, 32'h7fffffff, 32'h0, 16'h0001);          // R9 addiu no trap
    apply(6'h0A, 6'h00, 0, 32'hfffffffe, 32'h0, 16'hffff);          // R5 slti signed
    apply(6'h0B, 6'h00, 0, 32'h00000005, 32'h0, 16'hffff);          // R7 sltiu large unsigned
    apply(6'h0B, 6'h00, 0, 32'hffffffff, 32'h0, 16'hffff);          // R7 equal not less
    apply(6'h0C, 6'h00, 0, 32'hffffffff, 32'h0, 16'h8421);          // R6 andi zero-extend
    apply(6'h0D, 6'h00, 0, 32'h00000000, 32'h0, 16'hf000);          // R6 ori zero-extend
    apply(6'h0F, 6'h00, 0, 32'hdeadbeef, 32'h0, 16'hbeef);          // R8 lui
    apply(6'h00, 6'h2A, 0, 32'hffffffff, 32'h1, 0);                 // R3 signed
    apply(6'h00, 6'h2B, 0, 32'hffffffff, 32'h1, 0);                 // R3 unsigned
    apply(6'h00, 6'h27, 0, 32'hf0f00000, 32'h0000f0f0, 0);          // R2 nor
    apply(6'h00, 6'h00, 5'd31, 32'hffffffff, 32'h00000003, 0);      // R4 sll, rs ignored
    apply(6'h00, 6'h02, 5'd31, 32'h12345678, 32'h80000000, 0);      // R4 srl
    apply(6'h00, 6'h26, 0, 32'h1, 32'h1, 0);                        // R10 unsupported funct
    apply(6'h23, 6'h00, 0, 32'h1, 32'h1, 16'h1);                    // R10 unsupported opcode
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] sel;
      int k;
      k = $urandom % 20;
      if (k < 18) sel = OPS[k];
      else sel = {6'($urandom), 6'($urandom)};
      if (k < 18 && sel[11:6] != 0) sel[5:0] = 6'($urandom);
      apply(sel[11:6], sel[5:0], 5'($urandom), pick(), pick(), 16'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule